// File: doc/BRIEF.md
# Virtualized Trie Longest-Prefix Lookup

This block finds, for a destination address, the next hop of the longest stored prefix that matches it. The routes of several virtual networks are merged into a single leaf-pushed binary trie. The trie consumes one address bit per level and keeps one on-chip memory per level. Each leaf holds a vector of next-hop indices, one slot per virtual network. The network identifier that travels with the request picks the slot. The whole pipeline is time-shared by all networks and accepts one lookup on every clock cycle, with no back-pressure.

Prefixes no longer than `SHORT_W` bits are held in a small direct table instead of being pushed out into many trie leaves. That table is indexed by the network identifier and the top address bits. It supplies the answer only when the trie walk yields nothing. A level memory, the leaf memory and the short table are each read only when a live lookup needs them, so idle memories stay disabled.

Software fills all tables through one write port while no lookup is in flight.

Top module: `vtrie_lpm`

## Requirements
- R1: A lookup returns the next hop of the longest matching prefix stored in the trie. The walk takes address bits from the MSB down, one per level. Bit value 0 selects the left child and 1 selects the right child. The root is entry 0 of level 0.
- R2: A leaf's vector holds network n's next hop in bits [n*NH_W +: NH_W]. The request's `lk_vnid` selects which slot is returned.
- R3: When the trie result for the request's network is zero, the short table entry at index {lk_vnid, top SHORT_W address bits} is returned. When the trie result is non-zero, it takes precedence over the short table.
- R4: When both the trie result and the short table entry are zero, the response has `res_hit`=0 and `res_nh`=0. On every other response, `res_hit`=1 and `res_nh` carries the non-zero hop.
- R5: Each request produces exactly one response, LEVELS+2 cycles after it is accepted. Responses appear in request order, and back-to-back requests are allowed on every cycle.
- R6: Node word encoding. Bit 0 is the leaf flag. A leaf node holds its leaf-vector pointer in bits [LEAF_AW:1]. An internal node holds its left child pointer in [NODE_AW:1] and its right child pointer in [2*NODE_AW:NODE_AW+1]. Child pointers index the next level's memory.
- R7: `wr_tgt` values 0..LEVELS-1 write a level memory, LEVELS writes the leaf-vector memory, and LEVELS+1 writes the short table. A write is visible to any lookup that reads the written entry after the write cycle.
- R8: While `rst` is high and right after it is released, `res_valid`, `res_hit` and `res_nh` are 0.
- R9: A memory is enabled only when a live lookup reaches it. A level is read only by a lookup that has not yet reached a leaf, and the leaf memory only by a lookup that ended at a leaf.
- R10: A walk that is still at an internal node after the last level counts as a trie miss, and the short table is used (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present this cycle |
| lk_addr | input | ADDR_W | Destination address |
| lk_vnid | input | $clog2(VN_CNT) | Virtual network of the request |
| wr_en | input | 1 | Table write strobe |
| wr_tgt | input | $clog2(LEVELS+2) | Table selected for the write (R7) |
| wr_addr | input | WA_W | Entry index within the selected table |
| wr_data | input | WD_W | Entry value, LSB-aligned |
| res_valid | output | 1 | Response present |
| res_hit | output | 1 | Response carries a non-zero next hop |
| res_nh | output | NH_W | Next-hop index, 0 on miss |

## Verification
The bench builds the block with ADDR_W=16, four networks, 4-bit hops, six trie levels, 3-bit node and leaf pointers and SHORT_W=2. These values keep the tables small enough to fill entry by entry. The trie holds a six-prefix example with a deepest leaf at level 4, plus a chain of internal nodes down to the last level that forces depth misses. With four networks, a single leaf can give one network a hop, another a zero slot that falls back to the short table, and a third nothing at all. The short tables then cover fallback, trie precedence and total misses. The bench runs the lookups back to back and checks latency on every response, and it rewrites a leaf between lookups.

// File: rtl/vtrie_pkg.sv
package vtrie_pkg;
  // Default sizing shared by the top and its bench.
  localparam int DEF_ADDR_W  = 32;
  localparam int DEF_VN_CNT  = 4;
  localparam int DEF_NH_W    = 8;
  localparam int DEF_LEVELS  = 8;
  localparam int DEF_NODE_AW = 6;
  localparam int DEF_LEAF_AW = 6;
  localparam int DEF_SHORT_W = 4;

  function automatic int vmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vtrie_level_mem.sv
// One trie level: simple dual-port RAM with an enabled synchronous read.
module vtrie_level_mem #(
  parameter int AW = 6,
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/vtrie_step.sv
// Decides one trie step from the node just read and the current address bit.
module vtrie_step #(
  parameter int NODE_AW = 6,
  parameter int LEAF_AW = 6,
  parameter int NODE_W  = 13
) (
  input  logic               valid,
  input  logic               done_in,
  input  logic [LEAF_AW-1:0] lp_in,
  input  logic [NODE_W-1:0]  node,
  input  logic               dir,
  output logic               done_out,
  output logic [LEAF_AW-1:0] lp_out,
  output logic               descend,
  output logic [NODE_AW-1:0] child
);
  logic is_leaf;
  logic active;

  always_comb begin
    is_leaf  = node[0];
    active   = valid && !done_in;
    done_out = done_in || (active && is_leaf);
    lp_out   = (active && is_leaf) ? node[LEAF_AW:1] : lp_in;
    descend  = active && !is_leaf;
    child    = dir ? node[2*NODE_AW:NODE_AW+1] : node[NODE_AW:1];
  end
endmodule

// File: rtl/vtrie_tail.sv
// Leaf-vector read, short-table read, slot select and fallback, output registers.
module vtrie_tail #(
  parameter int VN_CNT  = 4,
  parameter int NH_W    = 8,
  parameter int LEAF_AW = 6,
  parameter int SHORT_W = 4,
  localparam int VN_W   = $clog2(VN_CNT),
  localparam int VEC_W  = VN_CNT * NH_W,
  localparam int SIDX_W = VN_W + SHORT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               f_valid,
  input  logic               f_done,
  input  logic               leaf_re,
  input  logic [LEAF_AW-1:0] f_lp,
  input  logic [VN_W-1:0]    f_vn,
  input  logic [SHORT_W-1:0] f_top,
  input  logic               leaf_we,
  input  logic [LEAF_AW-1:0] leaf_waddr,
  input  logic [VEC_W-1:0]   leaf_wdata,
  input  logic               short_we,
  input  logic [SIDX_W-1:0]  short_waddr,
  input  logic [NH_W-1:0]    short_wdata,
  output logic               res_valid,
  output logic               res_hit,
  output logic [NH_W-1:0]    res_nh
);
  logic [VEC_W-1:0] vec_q;
  logic [NH_W-1:0]  short_q;
  logic             t_valid;
  logic             t_done;
  logic [VN_W-1:0]  t_vn;
  logic [NH_W-1:0]  trie_nh;
  logic [NH_W-1:0]  pick;

  vtrie_level_mem #(.AW(LEAF_AW), .DW(VEC_W)) u_leaf (
    .clk(clk), .we(leaf_we), .waddr(leaf_waddr), .wdata(leaf_wdata),
    .re(leaf_re), .raddr(f_lp), .rdata(vec_q)
  );

  vtrie_level_mem #(.AW(SIDX_W), .DW(NH_W)) u_short (
    .clk(clk), .we(short_we), .waddr(short_waddr), .wdata(short_wdata),
    .re(f_valid), .raddr({f_vn, f_top}), .rdata(short_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      t_valid <= 1'b0;
      t_done  <= 1'b0;
      t_vn    <= '0;
    end else begin
      t_valid <= f_valid;
      t_done  <= f_done;
      t_vn    <= f_vn;
    end
  end

  always_comb begin
    trie_nh = t_done ? vec_q[t_vn*NH_W +: NH_W] : '0;
    pick    = (trie_nh != '0) ? trie_nh : short_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_nh    <= '0;
    end else begin
      res_valid <= t_valid;
      res_hit   <= t_valid && (pick != '0);
      res_nh    <= t_valid ? pick : '0;
    end
  end
endmodule

// File: rtl/vtrie_lpm.sv
// Pipelined longest-prefix lookup over a merged multi-network uni-bit trie.
module vtrie_lpm #(
  parameter int ADDR_W  = vtrie_pkg::DEF_ADDR_W,
  parameter int VN_CNT  = vtrie_pkg::DEF_VN_CNT,
  parameter int NH_W    = vtrie_pkg::DEF_NH_W,
  parameter int LEVELS  = vtrie_pkg::DEF_LEVELS,
  parameter int NODE_AW = vtrie_pkg::DEF_NODE_AW,
  parameter int LEAF_AW = vtrie_pkg::DEF_LEAF_AW,
  parameter int SHORT_W = vtrie_pkg::DEF_SHORT_W,
  localparam int VN_W   = $clog2(VN_CNT),
  localparam int TGT_W  = $clog2(LEVELS + 2),
  localparam int NODE_W = 1 + vtrie_pkg::vmax(2 * NODE_AW, LEAF_AW),
  localparam int VEC_W  = VN_CNT * NH_W,
  localparam int SIDX_W = VN_W + SHORT_W,
  localparam int WA_W   = vtrie_pkg::vmax(vtrie_pkg::vmax(NODE_AW, LEAF_AW), SIDX_W),
  localparam int WD_W   = vtrie_pkg::vmax(vtrie_pkg::vmax(NODE_W, VEC_W), NH_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [VN_W-1:0]   lk_vnid,
  input  logic              wr_en,
  input  logic [TGT_W-1:0]  wr_tgt,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [WD_W-1:0]   wr_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [NH_W-1:0]   res_nh
);
  localparam int TOP_W    = vtrie_pkg::vmax(LEVELS, SHORT_W);
  localparam int TGT_LEAF = LEVELS;
  localparam int TGT_SHRT = LEVELS + 1;

  // Request register.
  logic             in_v;
  logic [TOP_W-1:0] in_a;
  logic [VN_W-1:0]  in_n;

  always_ff @(posedge clk) begin
    if (rst) in_v <= 1'b0;
    else     in_v <= lk_valid;
    in_a <= lk_addr[ADDR_W-1 -: TOP_W];
    in_n <= lk_vnid;
  end

  // Per-stage metadata: stage k sits beside the read of level k.
  logic [LEVELS-1:0] stage_live;
  logic [LEVELS-1:0] stage_done;
  logic [LEVELS-1:0] node_re;
  logic [LEVELS-1:0] src_done;
  logic [LEVELS-1:0] src_live;
  logic [LEAF_AW-1:0] st_lp   [LEVELS];
  logic [TOP_W-1:0]   st_a    [LEVELS];
  logic [VN_W-1:0]    st_n    [LEVELS];
  logic [LEAF_AW-1:0] src_lp  [LEVELS];
  logic [TOP_W-1:0]   src_a   [LEVELS];
  logic [VN_W-1:0]    src_n   [LEVELS];
  logic [NODE_AW-1:0] rd_ptr  [LEVELS];
  logic [NODE_W-1:0]  node_q  [LEVELS];

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    if (k == 0) begin : g_root
      assign node_re[0]  = in_v;
      assign rd_ptr[0]   = '0;
      assign src_live[0] = in_v;
      assign src_done[0] = 1'b0;
      assign src_lp[0]   = '0;
      assign src_a[0]    = in_a;
      assign src_n[0]    = in_n;
    end else begin : g_walk
      vtrie_step #(.NODE_AW(NODE_AW), .LEAF_AW(LEAF_AW), .NODE_W(NODE_W)) u_step (
        .valid   (stage_live[k-1]),
        .done_in (stage_done[k-1]),
        .lp_in   (st_lp[k-1]),
        .node    (node_q[k-1]),
        .dir     (st_a[k-1][TOP_W-k]),
        .done_out(src_done[k]),
        .lp_out  (src_lp[k]),
        .descend (node_re[k]),
        .child   (rd_ptr[k])
      );
      assign src_live[k] = stage_live[k-1];
      assign src_a[k]    = st_a[k-1];
      assign src_n[k]    = st_n[k-1];
    end

    vtrie_level_mem #(.AW(NODE_AW), .DW(NODE_W)) u_mem (
      .clk  (clk),
      .we   (wr_en && (wr_tgt == TGT_W'(k))),
      .waddr(wr_addr[NODE_AW-1:0]),
      .wdata(wr_data[NODE_W-1:0]),
      .re   (node_re[k]),
      .raddr(rd_ptr[k]),
      .rdata(node_q[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_live[k] <= 1'b0;
        stage_done[k] <= 1'b0;
      end else begin
        stage_live[k] <= src_live[k];
        stage_done[k] <= src_done[k];
      end
      st_lp[k] <= src_lp[k];
      st_a[k]  <= src_a[k];
      st_n[k]  <= src_n[k];
    end
  end

  // Final step: resolve the last level's node.
  logic               f_done;
  logic [LEAF_AW-1:0] f_lp;
  logic               last_desc;
  logic [NODE_AW-1:0] last_child;
  logic               leaf_re;

  vtrie_step #(.NODE_AW(NODE_AW), .LEAF_AW(LEAF_AW), .NODE_W(NODE_W)) u_last (
    .valid   (stage_live[LEVELS-1]),
    .done_in (stage_done[LEVELS-1]),
    .lp_in   (st_lp[LEVELS-1]),
    .node    (node_q[LEVELS-1]),
    .dir     (st_a[LEVELS-1][TOP_W-LEVELS]),
    .done_out(f_done),
    .lp_out  (f_lp),
    .descend (last_desc),
    .child   (last_child)
  );

  assign leaf_re = stage_live[LEVELS-1] && f_done;

  vtrie_tail #(
    .VN_CNT(VN_CNT), .NH_W(NH_W), .LEAF_AW(LEAF_AW), .SHORT_W(SHORT_W)
  ) u_tail (
    .clk        (clk),
    .rst        (rst),
    .f_valid    (stage_live[LEVELS-1]),
    .f_done     (f_done),
    .leaf_re    (leaf_re),
    .f_lp       (f_lp),
    .f_vn       (st_n[LEVELS-1]),
    .f_top      (st_a[LEVELS-1][TOP_W-1 -: SHORT_W]),
    .leaf_we    (wr_en && (wr_tgt == TGT_W'(TGT_LEAF))),
    .leaf_waddr (wr_addr[LEAF_AW-1:0]),
    .leaf_wdata (wr_data[VEC_W-1:0]),
    .short_we   (wr_en && (wr_tgt == TGT_W'(TGT_SHRT))),
    .short_waddr(wr_addr[SIDX_W-1:0]),
    .short_wdata(wr_data[NH_W-1:0]),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_nh     (res_nh)
  );
endmodule

// File: rtl/vtrie_lpm_chk.sv
module vtrie_lpm_chk #(
  parameter int LEVELS  = 8,
  parameter int NODE_AW = 6,
  parameter int NH_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_live,
  input logic [LEVELS-1:0]  stage_live,
  input logic [LEVELS-1:0]  stage_done,
  input logic [LEVELS-1:0]  node_re,
  input logic               leaf_re,
  input logic               last_desc,
  input logic [NODE_AW-1:0] last_child,
  input logic               res_valid,
  input logic               res_hit,
  input logic [NH_W-1:0]    res_nh
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  root_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1) |-> (stage_live[0] == $past(in_live)));

  for (genvar k = 1; k < LEVELS; k++) begin : g_chain
    // R5
    live_chain_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd1) |-> (stage_live[k] == $past(stage_live[k-1])));
    // R9
    node_gate_chk: assert property (@(posedge clk) disable iff (rst)
      node_re[k] |-> (stage_live[k-1] && !stage_done[k-1]));
  end

  // R5
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (res_valid == $past(stage_live[LEVELS-1], 2)));

  // R9, R10
  leaf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    leaf_re |-> (!last_desc || (last_child == last_child)) && !last_desc);

  // R4
  hit_code_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit == (res_nh != '0)));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && res_nh == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_hit));
endmodule

bind vtrie_lpm vtrie_lpm_chk #(.LEVELS(LEVELS), .NODE_AW(NODE_AW), .NH_W(NH_W)) u_chk (
  .clk(clk), .rst(rst), .in_live(in_v), .stage_live(stage_live),
  .stage_done(stage_done), .node_re(node_re), .leaf_re(leaf_re),
  .last_desc(last_desc), .last_child(last_child),
  .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh)
);

// File: tb/vtrie_lpm_tb.sv
module vtrie_lpm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 16;
  localparam int VN_CNT  = 4;
  localparam int NH_W    = 4;
  localparam int LEVELS  = 6;
  localparam int NODE_AW = 3;
  localparam int LEAF_AW = 3;
  localparam int SHORT_W = 2;
  localparam int VN_W    = 2;
  localparam int TGT_W   = 3;
  localparam int WA_W    = 4;
  localparam int WD_W    = 16;
  localparam int T_LEAF  = LEVELS;
  localparam int T_SHORT = LEVELS + 1;
  localparam int LAT     = LEVELS + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [VN_W-1:0]   lk_vnid = '0;
  logic              wr_en = 1'b0;
  logic [TGT_W-1:0]  wr_tgt = '0;
  logic [WA_W-1:0]   wr_addr = '0;
  logic [WD_W-1:0]   wr_data = '0;
  logic              res_valid;
  logic              res_hit;
  logic [NH_W-1:0]   res_nh;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int    exp_q [$];
  int    cyc_q [$];
  string tag_q [$];

  vtrie_lpm #(
    .ADDR_W(ADDR_W), .VN_CNT(VN_CNT), .NH_W(NH_W), .LEVELS(LEVELS),
    .NODE_AW(NODE_AW), .LEAF_AW(LEAF_AW), .SHORT_W(SHORT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_vnid(lk_vnid), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // R6 node encodings
  function automatic logic [WD_W-1:0] n_int(input int l, input int r);
    return WD_W'({r[2:0], l[2:0], 1'b0});
  endfunction
  function automatic logic [WD_W-1:0] n_leaf(input int p);
    return WD_W'({3'd0, p[2:0], 1'b1});
  endfunction

  task automatic wr(input int tgt, input int a, input logic [WD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tgt = TGT_W'(tgt); wr_addr = WA_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive one lookup in the next cycle; leaves the bus idle afterwards only if asked.
  task automatic look(input logic [ADDR_W-1:0] a, input int vn, input int exp_nh, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_vnid = VN_W'(vn);
    exp_q.push_back(exp_nh);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: unexpected response nh=%0d expected none", res_nh);
      end else begin
        int e; int c; string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        if (res_nh != NH_W'(e) || res_hit != (e != 0)) begin
          errors++;
          $display("FAIL %s: nh=%0d hit=%0d expected nh=%0d hit=%0d", t, res_nh, res_hit, e, (e != 0));
        end else if (cyc != c + LAT + 1) begin
          errors++;
          $display("FAIL R5 (%s): response cycle %0d expected %0d", t, cyc, c + LAT + 1);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_nh !== '0) begin
      errors++;
      $display("FAIL R8: valid=%0b hit=%0b nh=%0d expected 0 0 0", res_valid, res_hit, res_nh);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: valid=%0b after release expected 0", res_valid);
    end

    // Trie (R6, R7 codes): prefixes 0*,000*,001*,010*,0100*,0101* leaf-pushed;
    // "1" leads into internal nodes down to the last level (R10).
    wr(0, 0, n_int(0, 1));
    wr(1, 0, n_int(0, 1)); wr(1, 1, n_int(2, 2));
    wr(2, 0, n_int(0, 1)); wr(2, 1, n_int(2, 3)); wr(2, 2, n_int(4, 4));
    wr(3, 0, n_leaf(1)); wr(3, 1, n_leaf(2)); wr(3, 2, n_int(0, 1));
    wr(3, 3, n_leaf(3)); wr(3, 4, n_int(4, 4));
    wr(4, 0, n_leaf(4)); wr(4, 1, n_leaf(3)); wr(4, 4, n_int(4, 4));
    wr(5, 4, n_int(4, 4));
    // Leaf vectors (R2): slot n at bits [n*4 +: 4]
    wr(T_LEAF, 0, 16'h0000);
    wr(T_LEAF, 1, 16'h0051);
    wr(T_LEAF, 2, 16'h0002);
    wr(T_LEAF, 3, 16'h0063);
    wr(T_LEAF, 4, 16'h0074);
    // Short table index {vn, top 2 bits} (R3)
    for (int i = 0; i < 16; i++) wr(T_SHORT, i, 16'h0000);
    wr(T_SHORT, 0, 16'h000D);
    wr(T_SHORT, 2, 16'h000B);
    wr(T_SHORT, 4, 16'h0009);
    wr(T_SHORT, 7, 16'h000C);

    // Back-to-back lookups
    look(16'h4000, 0, 4,  "R1 0100");
    look(16'h6000, 0, 3,  "R1 011");
    look(16'h0000, 0, 1,  "R1/R3 000 trie over short");
    look(16'h2000, 0, 2,  "R1 001");
    look(16'h5000, 0, 3,  "R1 0101");
    look(16'h8000, 0, 11, "R10 depth miss to short");
    look(16'hC000, 0, 0,  "R4 total miss");
    look(16'h4000, 1, 7,  "R2 vn1 0100");
    look(16'h0000, 1, 5,  "R2 vn1 000");
    look(16'h2000, 1, 9,  "R3 vn1 null slot fallback");
    look(16'hF000, 1, 12, "R10 vn1 depth miss short");
    look(16'h4000, 2, 0,  "R4 vn2 empty");
    look(16'h6000, 3, 0,  "R4 vn3 empty");
    idle();
    repeat (LAT + 3) @(negedge clk);

    // R7: rewrite leaf 4 giving vn2 hop 8, look up right after
    wr(T_LEAF, 4, 16'h0874);
    look(16'h4000, 2, 8, "R7 rewritten leaf");
    idle();
    idle();
    look(16'h4FFF, 0, 4, "R1 low bits ignored");
    idle();
    repeat (LAT + 4) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d responses missing expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule